// File: doc/BRIEF.md
# Two-Bank Pulse/Receive Sequencer

This block runs the firing and listening cycle of a four-channel ultrasonic pulser/receiver board that owns a single digitizer. The channels form two banks of two, and the banks take turns. A trigger comes from one of two sources. In synchronized mode it is the rising edge of a strobe shared by many boards, so that all boards fire the same bank together. In standalone mode it comes from an on-board repetition timer that runs on the block clock.

For each accepted trigger the block does four things. It drives the pulser enables of the enabled channels in the current bank for a programmed number of cycles. It points the input multiplexer at exactly one of those channels. It waits a fixed settling time. It then raises a receive-active strobe for a programmed window. A trigger that arrives while a sequence is still running is flagged as an overrun and has no other effect. A bank with no enabled channel is passed over without firing.

The controlling processor loads four settings through a small write port before operation: pulse length, window length, channel enables and the repetition divisor.

Top module: `bank_fire_seq`

## Requirements
- R1: In synchronized mode (standalone_i low), a rising edge on sync_i is passed through a two-stage synchronizer and edge detector. If the block is idle, the edge starts a sequence, and pulse_o first goes nonzero in the third clock cycle after the cycle in which sync_i rose.
- R2: Bank 0 is channels 0 and 1 (pulse_o bits 1:0). Bank 1 is channels 2 and 3 (bits 3:2). The first accepted trigger after reset serves bank 0, and every accepted trigger moves to the other bank.
- R3: pulse_o drives, for exactly the programmed pulse length in cycles (a value of 0 acts as 1), the bits of the enabled channels of the served bank and no other bits.
- R4: mux_sel_o gives the index (0 to 3) of the one channel received in a sequence, and that channel is among the fired ones. Within a bank, the received channel rotates among the enabled channels, starting with the lower index after reset. When only one channel of the bank is enabled, that channel is always received.
- R5: rx_active_o rises exactly SETTLE (default 4) cycles after the last pulse cycle. It stays high for the programmed window length (0 acts as 1). pulse_o is zero while rx_active_o is high.
- R6: mux_sel_o does not change from the first pulse cycle of a sequence until the window closes.
- R7: A trigger that arrives while a sequence runs raises overrun_o for one cycle. It starts nothing and does not change the bank that the next trigger serves.
- R8: A trigger that serves a bank with no enabled channel produces no pulse and no window, and the bank still switches.
- R9: In standalone mode, triggers occur every max(divisor,1) cycles, and sync_i has no effect. In synchronized mode the timer is held and produces no trigger.
- R10: Writes with cfg_we_i high load the setting selected by cfg_addr_i: 0 is pulse length (bits 7:0), 1 is window length (bits 11:0), 2 is channel enables (bits 3:0, bit n is channel n), and 3 is the divisor (bits 15:0). The reset values are 8, 32, 4'hF and 1000. After reset all outputs are low and mux_sel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, converter rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Asynchronous fire strobe shared between boards |
| standalone_i | input | 1 | 1 selects the internal repetition timer |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_addr_i | input | 2 | Setting select |
| cfg_wdata_i | input | 16 | Setting write data |
| pulse_o | output | 4 | Pulser enable per channel |
| mux_sel_o | output | 2 | Receive multiplexer select |
| rx_active_o | output | 1 | Receive window open |
| overrun_o | output | 1 | One-cycle flag for a trigger dropped while busy |

## Verification
The main sequence is exercised with the power-up settings, with both channels of a bank enabled (this exposes the rotation of the received channel), with one channel per bank (the rotation must stop), with zero lengths (this separates a correct floor of one cycle from a missing or wrap-around count), and with an empty bank (this shows whether a skip still advances the bank). A strobe injected during an open window shows whether overruns are dropped without disturbing the bank order. A standalone run with strobes toggling on sync_i tells the timer period apart from any leak of the external edge. A scoreboard predicts the mask, channel, latency and phase lengths of each sequence from the settings alone.

// File: rtl/bank_fire_pkg.sv
package bank_fire_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRE,
    ST_SETTLE,
    ST_LISTEN
  } seq_state_e;

  localparam logic [1:0] ADDR_PULSE = 2'd0;
  localparam logic [1:0] ADDR_WIN   = 2'd1;
  localparam logic [1:0] ADDR_EN    = 2'd2;
  localparam logic [1:0] ADDR_DIV   = 2'd3;
endpackage

// File: rtl/bank_fire_sync.sv
module bank_fire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R1
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bank_fire_timer.sv
module bank_fire_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick_o = en_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

  // R9
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && en_i && div_i > DIV_W'(1) && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/bank_fire_cfg.sv
module bank_fire_cfg
  import bank_fire_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int PULSE_W   = 8,
  parameter int WIN_W     = 12,
  parameter int NUM_CH    = 4,
  parameter int DIV_W     = 16,
  parameter int PULSE_RST = 8,
  parameter int WIN_RST   = 32,
  parameter int EN_RST    = 15,
  parameter int DIV_RST   = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [CFG_W-1:0]   wdata_i,
  output logic [PULSE_W-1:0] pulse_len_o,
  output logic [WIN_W-1:0]   win_len_o,
  output logic [NUM_CH-1:0]  ch_en_o,
  output logic [DIV_W-1:0]   rep_div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_len_o <= PULSE_W'(PULSE_RST);
      win_len_o   <= WIN_W'(WIN_RST);
      ch_en_o     <= NUM_CH'(EN_RST);
      rep_div_o   <= DIV_W'(DIV_RST);
    end else if (we_i) begin
      case (addr_i)
        ADDR_PULSE: pulse_len_o <= wdata_i[PULSE_W-1:0];
        ADDR_WIN:   win_len_o   <= wdata_i[WIN_W-1:0];
        ADDR_EN:    ch_en_o     <= wdata_i[NUM_CH-1:0];
        default:    rep_div_o   <= wdata_i[DIV_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/bank_fire_ctrl.sv
module bank_fire_ctrl
  import bank_fire_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int CH_PER_BANK = 2,
  parameter int PULSE_W     = 8,
  parameter int WIN_W       = 12,
  parameter int SETTLE      = 4,
  localparam int NUM_CH     = NUM_BANKS * CH_PER_BANK,
  localparam int SEL_W      = $clog2(NUM_CH),
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LANE_W     = (CH_PER_BANK > 1) ? $clog2(CH_PER_BANK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic [PULSE_W-1:0] pulse_len_i,
  input  logic [WIN_W-1:0]   win_len_i,
  input  logic [NUM_CH-1:0]  ch_en_i,
  output logic [NUM_CH-1:0]  pulse_o,
  output logic [SEL_W-1:0]   mux_sel_o,
  output logic               rx_active_o,
  output logic               overrun_o
);
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam int MAX_PW = (PULSE_W > WIN_W) ? PULSE_W : WIN_W;
  localparam int CNT_W  = (MAX_PW > SET_W) ? MAX_PW : SET_W;

  seq_state_e              state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [BANK_W-1:0]       bank_q, bank_nxt;
  logic [LANE_W-1:0]       last_q [NUM_BANKS];
  logic [LANE_W-1:0]       lane_nxt;
  logic [CH_PER_BANK-1:0]  bank_en;
  logic [NUM_CH-1:0]       pulse_q, pulse_nxt;
  logic [SEL_W-1:0]        mux_q, mux_nxt;
  logic                    overrun_q;
  logic [CNT_W-1:0]        pulse_ld, win_ld;

  assign pulse_ld = (pulse_len_i == '0) ? '0 : CNT_W'(pulse_len_i) - CNT_W'(1);
  assign win_ld   = (win_len_i == '0) ? '0 : CNT_W'(win_len_i) - CNT_W'(1);
  assign bank_nxt = (int'(bank_q) == NUM_BANKS - 1) ? '0 : bank_q + BANK_W'(1);
  assign bank_en  = ch_en_i[int'(bank_q)*CH_PER_BANK +: CH_PER_BANK];

  // next receive lane: first enabled lane after the last one served in this bank
  always_comb begin
    logic found;
    found    = 1'b0;
    lane_nxt = last_q[bank_q];
    for (int k = 1; k <= CH_PER_BANK; k++) begin
      if (!found && bank_en[(int'(last_q[bank_q]) + k) % CH_PER_BANK]) begin
        lane_nxt = LANE_W'((int'(last_q[bank_q]) + k) % CH_PER_BANK);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    pulse_nxt = '0;
    pulse_nxt[int'(bank_q)*CH_PER_BANK +: CH_PER_BANK] = bank_en;
    mux_nxt = SEL_W'(int'(bank_q) * CH_PER_BANK + int'(lane_nxt));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bank_q    <= '0;
      pulse_q   <= '0;
      mux_q     <= '0;
      overrun_q <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) last_q[b] <= LANE_W'(CH_PER_BANK - 1);
    end else begin
      overrun_q <= trig_i && (state_q != ST_IDLE);
      case (state_q)
        ST_IDLE: begin
          if (trig_i) begin
            bank_q <= bank_nxt;
            if (|bank_en) begin
              state_q        <= ST_FIRE;
              cnt_q          <= pulse_ld;
              pulse_q        <= pulse_nxt;
              mux_q          <= mux_nxt;
              last_q[bank_q] <= lane_nxt;
            end
          end
        end
        ST_FIRE: begin
          if (cnt_q == '0) begin
            state_q <= ST_SETTLE;
            cnt_q   <= CNT_W'(SETTLE - 1);
            pulse_q <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_SETTLE: begin
          if (cnt_q == '0) begin
            state_q <= ST_LISTEN;
            cnt_q   <= win_ld;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
      endcase
    end
  end

  assign pulse_o     = pulse_q;
  assign mux_sel_o   = mux_q;
  assign rx_active_o = (state_q == ST_LISTEN);
  assign overrun_o   = overrun_q;

  // R7
  listen_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LISTEN) |=> (state_q == ST_LISTEN || state_q == ST_IDLE));

  // R6
  mux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(mux_q));

  // R5
  rx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_o |-> (pulse_o == '0));

  // R4
  rx_fired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o != '0) |-> pulse_o[mux_q]);

  // R3
  pulse_one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pulse_o) <= CH_PER_BANK);
endmodule

// File: rtl/bank_fire_seq.sv
module bank_fire_seq #(
  parameter int NUM_BANKS   = 2,
  parameter int CH_PER_BANK = 2,
  parameter int CFG_W       = 16,
  parameter int PULSE_W     = 8,
  parameter int WIN_W       = 12,
  parameter int DIV_W       = 16,
  parameter int SETTLE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              standalone_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [3:0]        pulse_o,
  output logic [1:0]        mux_sel_o,
  output logic              rx_active_o,
  output logic              overrun_o
);
  localparam int NUM_CH = NUM_BANKS * CH_PER_BANK;
  localparam int SEL_W  = $clog2(NUM_CH);

  logic               sync_rise, tick, trig;
  logic [PULSE_W-1:0] pulse_len;
  logic [WIN_W-1:0]   win_len;
  logic [NUM_CH-1:0]  ch_en, pulse_int;
  logic [DIV_W-1:0]   rep_div;
  logic [SEL_W-1:0]   mux_int;

  bank_fire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(sync_i), .rise_o(sync_rise)
  );

  bank_fire_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(standalone_i), .div_i(rep_div), .tick_o(tick)
  );

  bank_fire_cfg #(
    .CFG_W(CFG_W), .PULSE_W(PULSE_W), .WIN_W(WIN_W), .NUM_CH(NUM_CH), .DIV_W(DIV_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .pulse_len_o(pulse_len), .win_len_o(win_len),
    .ch_en_o(ch_en), .rep_div_o(rep_div)
  );

  assign trig = standalone_i ? tick : sync_rise;

  bank_fire_ctrl #(
    .NUM_BANKS(NUM_BANKS), .CH_PER_BANK(CH_PER_BANK), .PULSE_W(PULSE_W),
    .WIN_W(WIN_W), .SETTLE(SETTLE)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .pulse_len_i(pulse_len),
    .win_len_i(win_len), .ch_en_i(ch_en), .pulse_o(pulse_int),
    .mux_sel_o(mux_int), .rx_active_o(rx_active_o), .overrun_o(overrun_o)
  );

  assign pulse_o   = 4'(pulse_int);
  assign mux_sel_o = 2'(mux_int);
endmodule

// File: tb/bank_fire_seq_test.sv
module bank_fire_seq_test;
  localparam int SETTLE_EXP = 4;
  localparam int LAT_EXP    = 3;

  typedef struct {
    logic [3:0] mask;
    int ch;
    int plen;
    int wlen;
    int t0;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic        standalone_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [3:0]  pulse_o;
  logic [1:0]  mux_sel_o;
  logic        rx_active_o, overrun_o;

  bank_fire_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_i), .standalone_i(standalone_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .pulse_o(pulse_o), .mux_sel_o(mux_sel_o), .rx_active_o(rx_active_o),
    .overrun_o(overrun_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int push_cnt = 0, done_cnt = 0, ovr_cnt = 0;
  item_t exp_q[$];
  int starts[$];
  bit finished = 0;

  // model shadow
  int m_bank = 0;
  int m_last[2] = '{1, 1};
  logic [3:0] m_en = 4'hF;
  int m_plen = 8, m_wlen = 32;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cfg_write(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = 16'(d);
    @(negedge clk);
    cfg_we_i = 1'b0;
    case (a)
      2'd0: m_plen = (d % 256 == 0) ? 1 : d % 256;
      2'd1: m_wlen = (d % 4096 == 0) ? 1 : d % 4096;
      2'd2: m_en = 4'(d);
      default: ;
    endcase
  endtask

  task automatic model_next(output item_t it, output bit has);
    logic [1:0] ben;
    ben = m_en[m_bank*2 +: 2];
    has = (ben != 2'b00);
    it.mask = '0; it.ch = 0; it.t0 = -1;
    it.plen = m_plen; it.wlen = m_wlen;
    if (has) begin
      bit found = 0;
      for (int k = 1; k <= 2; k++) begin
        int idx = (m_last[m_bank] + k) % 2;
        if (!found && ben[idx]) begin
          m_last[m_bank] = idx;
          found = 1;
        end
      end
      it.mask = 4'(ben) << (m_bank * 2);
      it.ch = m_bank * 2 + m_last[m_bank];
    end
    m_bank = 1 - m_bank;
  endtask

  task automatic strobe();
    sync_i = 1'b1;
    repeat (4) @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic fire_once();
    item_t it;
    bit has;
    model_next(it, has);
    @(negedge clk);
    it.t0 = cyc;
    if (has) begin
      exp_q.push_back(it);
      push_cnt++;
    end
    strobe();
    if (has) wait (done_cnt == push_cnt);
    else repeat (20) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  int ms = 0, pw = 0, gap = 0, rw = 0;
  item_t cur;
  logic [1:0] m_mux;
  bit mux_bad = 0, busy_pulse = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (overrun_o) ovr_cnt++;
      case (ms)
        0: begin
          if (pulse_o != 4'h0) begin
            if (exp_q.size() == 0) begin
              chk(0, "R2 unexpected firing", int'(pulse_o), 0);
              ms = 4;
            end else begin
              cur = exp_q.pop_front();
              chk(pulse_o == cur.mask, "R3 pulse mask", int'(pulse_o), int'(cur.mask));
              chk(int'(mux_sel_o) == cur.ch, "R4 receive channel", int'(mux_sel_o), cur.ch);
              if (cur.t0 >= 0) chk(cyc - cur.t0 == LAT_EXP, "R1 latency", cyc - cur.t0, LAT_EXP);
              starts.push_back(cyc);
              pw = 1; m_mux = mux_sel_o; mux_bad = 0; busy_pulse = 0;
              ms = 1;
            end
          end else if (rx_active_o) begin
            chk(0, "R8 window without pulse", 1, 0);
          end
        end
        1: begin
          if (mux_sel_o != m_mux) mux_bad = 1;
          if (pulse_o != 4'h0) pw++;
          else begin
            chk(pw == cur.plen, "R3 pulse length", pw, cur.plen);
            gap = 1;
            ms = 2;
          end
        end
        2: begin
          if (mux_sel_o != m_mux) mux_bad = 1;
          if (pulse_o != 4'h0) busy_pulse = 1;
          if (rx_active_o) begin
            chk(gap == SETTLE_EXP, "R5 settle gap", gap, SETTLE_EXP);
            rw = 1;
            ms = 3;
          end else gap++;
        end
        3: begin
          if (mux_sel_o != m_mux) mux_bad = 1;
          if (pulse_o != 4'h0) busy_pulse = 1;
          if (rx_active_o) rw++;
          else begin
            chk(rw == cur.wlen, "R5 window length", rw, cur.wlen);
            chk(!mux_bad, "R6 mux stable", int'(mux_bad), 0);
            chk(!busy_pulse, "R5 no pulse after fire", int'(busy_pulse), 0);
            done_cnt++;
            ms = 0;
          end
        end
        default: if (pulse_o == 4'h0 && !rx_active_o) ms = 0;
      endcase
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(pulse_o == 4'h0, "R10 reset pulse", int'(pulse_o), 0);
    chk(mux_sel_o == 2'd0, "R10 reset mux", int'(mux_sel_o), 0);
    chk(!rx_active_o && !overrun_o, "R10 reset strobes", int'(rx_active_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R4 R10: power-up settings, both channels enabled, rotation
    for (int i = 0; i < 4; i++) fire_once();

    // R4: one channel per bank, fixed receive
    cfg_write(2'd0, 3);
    cfg_write(2'd1, 5);
    cfg_write(2'd2, 4'b1001);
    for (int i = 0; i < 4; i++) fire_once();

    // R3 R5: zero lengths act as one
    cfg_write(2'd0, 0);
    cfg_write(2'd1, 0);
    cfg_write(2'd2, 4'b0110);
    for (int i = 0; i < 2; i++) fire_once();

    // R8: empty bank 0 is skipped but bank still alternates
    cfg_write(2'd0, 2);
    cfg_write(2'd1, 6);
    cfg_write(2'd2, 4'b1100);
    for (int i = 0; i < 4; i++) fire_once();

    // R7: strobe during an open window
    cfg_write(2'd1, 32);
    cfg_write(2'd2, 4'hF);
    ovr_cnt = 0;
    begin
      item_t it;
      bit has;
      model_next(it, has);
      @(negedge clk);
      it.t0 = cyc;
      exp_q.push_back(it);
      push_cnt++;
      strobe();
      while (!rx_active_o) @(negedge clk);
      strobe();
      wait (done_cnt == push_cnt);
      repeat (3) @(negedge clk);
    end
    chk(ovr_cnt == 1, "R7 overrun flagged", ovr_cnt, 1);
    fire_once();   // bank order must be unaffected by the dropped strobe
    chk(ovr_cnt == 1, "R7 no spurious overrun", ovr_cnt, 1);

    // R9: standalone timer, sync ignored
    cfg_write(2'd0, 4);
    cfg_write(2'd1, 10);
    cfg_write(2'd3, 60);
    begin
      item_t it;
      bit has;
      for (int i = 0; i < 4; i++) begin
        model_next(it, has);
        it.t0 = -1;
        exp_q.push_back(it);
        push_cnt++;
      end
    end
    base = starts.size();
    @(negedge clk);
    standalone_i = 1'b1;
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          repeat (25) @(negedge clk);
          strobe();
        end
      end
      wait (done_cnt == push_cnt);
    join_any
    wait (done_cnt == push_cnt);
    standalone_i = 1'b0;
    sync_i = 1'b0;
    repeat (100) @(negedge clk);
    for (int i = base + 1; i < base + 4; i++)
      chk(starts[i] - starts[i-1] == 60, "R9 period", starts[i] - starts[i-1], 60);
    chk(exp_q.size() == 0, "R9 no extra firing", exp_q.size(), 0);

    // R9: divisor 0 acts as 1 would fire constantly; instead check sync mode holds timer
    chk(starts.size() == base + 4, "R9 timer silent in sync mode", starts.size(), base + 4);

    finished = 1;
    summary();
  end
endmodule